// File: doc/BRIEF.md
# Packetized Receive Byte Framer

This block sits behind a serial deserializer and turns its stream of received bytes into packets. Each byte that arrives with its valid strobe is placed into a 32-bit assembly word. When the word is full, it goes out on the write port of an external receive data queue. Every packet begins on a fresh word. When a packet closes, any partly filled word is written out as well, and the lanes that were never filled read as zero.

A packet closes in one of two ways, chosen by a mode input. In count mode it closes when its byte count reaches a programmed length. In idle mode it closes when the line has carried no byte for a programmed number of clock cycles. In either mode, the byte count of each closed packet goes out on the write port of a separate length queue. Software can then split the packed data back into packets.

If a queue reports full at the moment a write is due, that write is dropped. Nothing already stored is touched, and a sticky overflow flag records the loss until reset.

Top module: `rx_pkt_framer`

## Requirements
- R1: Bytes fill the assembly word starting at bits 7:0 and moving upward one byte lane per byte. The fourth byte of a word produces a data write carrying all four bytes, visible on the output in the clock cycle after the edge that took that byte.
- R2: When a packet closes with 1, 2 or 3 bytes in its last word, that word is written together with the length entry. Every lane above the used ones is zero. A packet whose byte count is a multiple of four writes no extra word.
- R3: In count mode (`mode_timeout` = 0), a packet closes on the byte that brings its count to `pkt_len_cfg`. A setting of 0 gives one-byte packets.
- R4: In count mode, idle cycles with no byte never close a packet.
- R5: In idle mode (`mode_timeout` = 1), an open packet closes after `idle_limit` consecutive cycles without a byte. The length entry appears in the cycle after the last of those idle edges. A gap of `idle_limit`-1 idle cycles keeps the packet open.
- R6: Every closed packet writes its byte count, which is always nonzero, to the length queue. The write happens in the same cycle as the packet's last data write, if there is one.
- R7: In either mode, a packet closes on its own when its count reaches 2^LEN_W-1. Later bytes start a new packet.
- R8: When `dfifo_full` is high in the cycle a word completes, that word is dropped and `ovf_flag` is set. The packet's length entry is still written.
- R9: When `lfifo_full` is high in the cycle a packet closes, the length entry is dropped and `ovf_flag` is set. Its data words are still written.
- R10: After reset, both write strobes and `ovf_flag` are low. Once set, `ovf_flag` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| mode_timeout | input | 1 | 0: close on byte count, 1: close on idle time |
| pkt_len_cfg | input | LEN_W | Programmed packet length in bytes |
| idle_limit | input | TO_W | Idle cycles that close a packet in idle mode |
| dfifo_full | input | 1 | Receive data queue cannot take a word |
| dfifo_wr | output | 1 | Data queue write strobe |
| dfifo_wdata | output | 32 | Packed data word |
| lfifo_full | input | 1 | Length queue cannot take an entry |
| lfifo_wr | output | 1 | Length queue write strobe |
| lfifo_wdata | output | LEN_W | Byte count of the closed packet |
| ovf_flag | output | 1 | Sticky: a write was dropped on a full queue |

## Verification
The bench sweeps packet lengths across every remainder modulo four, in both modes and for several idle limits. A packer that padded with stale bytes, emitted an empty trailing word, or misplaced lanes would then produce words that differ from the arithmetic model. Idle timing is probed one cycle either side of the limit, so an off-by-one timer would close early or late. A stream longer than the count ceiling checks that a saturating design still splits the packet instead of wrapping to a zero length. Each full input is held during a packet to show that only the matching write is lost, that the other queue still receives its entries, and that the overflow flag stays set until reset.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTES_PER_WORD = 4;
  localparam int WORD_W         = 8 * BYTES_PER_WORD;

  typedef enum logic {
    END_BY_COUNT = 1'b0,
    END_BY_IDLE  = 1'b1
  } end_mode_e;
endpackage

// File: rtl/rxf_lane_packer.sv
// Collects accepted bytes into one word, lowest lane first; clears after each emit.
module rxf_lane_packer #(
  parameter  int WORD_BYTES = 4,
  localparam int WORD_W     = 8 * WORD_BYTES,
  localparam int LANE_W     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [7:0]        din,
  input  logic              close,
  output logic              emit,
  output logic [WORD_W-1:0] word
);
  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] acc_q;
  logic              last_lane;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign word[8*k +: 8] = (take && lane_q == LANE_W'(k)) ? din : acc_q[8*k +: 8];
  end

  assign last_lane = (lane_q == LANE_W'(WORD_BYTES - 1));
  // a word leaves when full, or at packet close if it holds anything
  assign emit = (take && last_lane) || (close && (take || lane_q != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (emit || close) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (take) begin
      lane_q <= lane_q + LANE_W'(1);
      acc_q  <= word;
    end
  end
endmodule

// File: rtl/rxf_end_detect.sv
// Decides where a packet ends: count reached, idle limit hit, or count ceiling.
module rxf_end_detect
  import rxf_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  end_mode_e        mode,
  input  logic [LEN_W-1:0] len_cfg,
  input  logic [TO_W-1:0]  limit,
  output logic             close,
  output logic [LEN_W-1:0] close_count
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_nxt;
  logic [TO_W-1:0]  idle_q;
  logic [TO_W:0]    idle_nxt;
  logic             open_q;
  logic             len_hit, cap_hit, idle_hit;

  assign cnt_nxt  = cnt_q + LEN_W'(take);
  assign idle_nxt = {1'b0, idle_q} + (TO_W+1)'(1);

  assign len_hit  = take && (mode == END_BY_COUNT) && (cnt_nxt >= len_cfg);
  assign cap_hit  = take && (&cnt_nxt);
  assign idle_hit = !take && open_q && (mode == END_BY_IDLE) && (idle_nxt >= {1'b0, limit});

  assign close       = len_hit || cap_hit || idle_hit;
  assign close_count = cnt_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      idle_q <= '0;
      open_q <= 1'b0;
    end else if (close) begin
      cnt_q  <= '0;
      idle_q <= '0;
      open_q <= 1'b0;
    end else if (take) begin
      cnt_q  <= cnt_nxt;
      idle_q <= '0;
      open_q <= 1'b1;
    end else if (open_q && mode == END_BY_IDLE) begin
      idle_q <= idle_nxt[TO_W-1:0];
    end
  end
endmodule

// File: rtl/rxf_wr_stage.sv
// Registered queue write ports; drops writes on full and records it.
module rxf_wr_stage #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_emit,
  input  logic [WORD_W-1:0] word,
  input  logic              pkt_close,
  input  logic [LEN_W-1:0]  pkt_count,
  input  logic              dfifo_full,
  input  logic              lfifo_full,
  output logic              dfifo_wr,
  output logic [WORD_W-1:0] dfifo_wdata,
  output logic              lfifo_wr,
  output logic [LEN_W-1:0]  lfifo_wdata,
  output logic              ovf_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dfifo_wr    <= 1'b0;
      dfifo_wdata <= '0;
      lfifo_wr    <= 1'b0;
      lfifo_wdata <= '0;
      ovf_flag    <= 1'b0;
    end else begin
      dfifo_wr <= word_emit && !dfifo_full;
      lfifo_wr <= pkt_close && !lfifo_full;
      if (word_emit) dfifo_wdata <= word;
      if (pkt_close) lfifo_wdata <= pkt_count;
      if ((word_emit && dfifo_full) || (pkt_close && lfifo_full)) ovf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_pkt_framer.sv
module rx_pkt_framer
  import rxf_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              mode_timeout,
  input  logic [LEN_W-1:0]  pkt_len_cfg,
  input  logic [TO_W-1:0]   idle_limit,
  input  logic              dfifo_full,
  output logic              dfifo_wr,
  output logic [WORD_W-1:0] dfifo_wdata,
  input  logic              lfifo_full,
  output logic              lfifo_wr,
  output logic [LEN_W-1:0]  lfifo_wdata,
  output logic              ovf_flag
);
  end_mode_e         mode;
  logic              pkt_close;
  logic [LEN_W-1:0]  pkt_count;
  logic              word_emit;
  logic [WORD_W-1:0] word;

  assign mode = end_mode_e'(mode_timeout);

  rxf_end_detect #(.LEN_W(LEN_W), .TO_W(TO_W)) i_end (
    .clk(clk), .rst(rst), .take(byte_valid), .mode(mode),
    .len_cfg(pkt_len_cfg), .limit(idle_limit),
    .close(pkt_close), .close_count(pkt_count)
  );

  rxf_lane_packer #(.WORD_BYTES(BYTES_PER_WORD)) i_pack (
    .clk(clk), .rst(rst), .take(byte_valid), .din(byte_data),
    .close(pkt_close), .emit(word_emit), .word(word)
  );

  rxf_wr_stage #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_wr (
    .clk(clk), .rst(rst), .word_emit(word_emit), .word(word),
    .pkt_close(pkt_close), .pkt_count(pkt_count),
    .dfifo_full(dfifo_full), .lfifo_full(lfifo_full),
    .dfifo_wr(dfifo_wr), .dfifo_wdata(dfifo_wdata),
    .lfifo_wr(lfifo_wr), .lfifo_wdata(lfifo_wdata),
    .ovf_flag(ovf_flag)
  );
endmodule

// File: rtl/rx_pkt_framer_chk.sv
module rx_pkt_framer_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_valid,
  input logic             mode_timeout,
  input logic [LEN_W-1:0] pkt_len_cfg,
  input logic             dfifo_full,
  input logic             lfifo_full,
  input logic             dfifo_wr,
  input logic [31:0]      dfifo_wdata,
  input logic             lfifo_wr,
  input logic [LEN_W-1:0] lfifo_wdata,
  input logic             ovf_flag
);
  logic [31:0] used_mask;
  always_comb begin
    case (lfifo_wdata[1:0])
      2'd1:    used_mask = 32'h0000_00FF;
      2'd2:    used_mask = 32'h0000_FFFF;
      2'd3:    used_mask = 32'h00FF_FFFF;
      default: used_mask = 32'hFFFF_FFFF;
    endcase
  end

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (lfifo_wr && dfifo_wr) |-> ((dfifo_wdata & ~used_mask) == 32'h0));

  // R3
  len_reach_chk: assert property (@(posedge clk) disable iff (rst)
    (lfifo_wr && !$past(mode_timeout)) |-> (lfifo_wdata >= $past(pkt_len_cfg)));

  // R4
  count_mode_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (lfifo_wr && !$past(mode_timeout)) |-> $past(byte_valid));

  // R6
  len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfifo_wr |-> (lfifo_wdata != '0));

  // R8
  dfull_drop_chk: assert property (@(posedge clk) disable iff (rst)
    dfifo_wr |-> !$past(dfifo_full));

  // R9
  lfull_drop_chk: assert property (@(posedge clk) disable iff (rst)
    lfifo_wr |-> !$past(lfifo_full));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);
endmodule

bind rx_pkt_framer rx_pkt_framer_chk #(.LEN_W(LEN_W)) i_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .mode_timeout(mode_timeout),
  .pkt_len_cfg(pkt_len_cfg), .dfifo_full(dfifo_full), .lfifo_full(lfifo_full),
  .dfifo_wr(dfifo_wr), .dfifo_wdata(dfifo_wdata), .lfifo_wr(lfifo_wr),
  .lfifo_wdata(lfifo_wdata), .ovf_flag(ovf_flag)
);

// File: tb/test_rx_pkt_framer.sv
module test_rx_pkt_framer;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 6;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic mode_timeout = 1'b0;
  logic [LW-1:0] pkt_len_cfg = '0;
  logic [TW-1:0] idle_limit = '0;
  logic dfifo_full = 1'b0;
  logic lfifo_full = 1'b0;
  logic dfifo_wr, lfifo_wr, ovf_flag;
  logic [31:0] dfifo_wdata;
  logic [LW-1:0] lfifo_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_framer #(.LEN_W(LW), .TO_W(TW)) i_rx_pkt_framer (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .mode_timeout(mode_timeout), .pkt_len_cfg(pkt_len_cfg), .idle_limit(idle_limit),
    .dfifo_full(dfifo_full), .dfifo_wr(dfifo_wr), .dfifo_wdata(dfifo_wdata),
    .lfifo_full(lfifo_full), .lfifo_wr(lfifo_wr), .lfifo_wdata(lfifo_wdata),
    .ovf_flag(ovf_flag)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] dlog [0:1023];
  logic [31:0] llog [0:1023];
  logic [31:0] dexp [0:1023];
  logic [31:0] lexp [0:1023];
  int dn = 0, ln = 0, den = 0, len_n = 0, dcur = 0, lcur = 0;
  int gseq = 0;

  always @(negedge clk) begin
    if (dfifo_wr && dn < 1024) begin dlog[dn] = dfifo_wdata; dn++; end
    if (lfifo_wr && ln < 1024) begin llog[ln] = 32'(lfifo_wdata); ln++; end
  end

  function automatic logic [7:0] bval(input int g);
    return 8'(g * 29 + 11);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte();
    byte_valid = 1'b1;
    byte_data  = bval(gseq);
    gseq++;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic send_n(input int n);
    for (int i = 0; i < n; i++) send_byte();
  endtask

  task automatic idle(input int n);
    byte_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_data(input int start, input int n);
    for (int j = 0; j < (n + 3) / 4; j++) begin
      logic [31:0] w = '0;
      for (int k = 0; k < 4; k++)
        if (4*j + k < n) w[8*k +: 8] = bval(start + 4*j + k);
      dexp[den] = w; den++;
    end
  endtask

  task automatic exp_len(input int n);
    lexp[len_n] = 32'(n); len_n++;
  endtask

  task automatic exp_pkt(input int start, input int n);
    exp_data(start, n);
    exp_len(n);
  endtask

  task automatic verify(input string req);
    check({req, " data word count"}, 32'(dn), 32'(den));
    check({req, " length entry count"}, 32'(ln), 32'(len_n));
    for (int i = dcur; i < dn && i < den; i++) check({req, " data word"}, dlog[i], dexp[i]);
    for (int i = lcur; i < ln && i < len_n; i++) check({req, " length entry"}, llog[i], lexp[i]);
    den = dn; len_n = ln; dcur = dn; lcur = ln;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    idle(3);
    // R10: reset state
    check("R10 reset dfifo_wr", 32'(dfifo_wr), 0);
    check("R10 reset lfifo_wr", 32'(lfifo_wr), 0);
    check("R10 reset ovf_flag", 32'(ovf_flag), 0);
    rst = 1'b0;
    idle(2);

    // R1: lane order and one-cycle write timing
    mode_timeout = 1'b0; pkt_len_cfg = 6'd9;
    s = gseq;
    send_n(3);
    check("R1 no write before word full", 32'(dfifo_wr), 0);
    send_n(1);
    check("R1 write strobe after 4th byte", 32'(dfifo_wr), 1);
    check("R1 lane order", dfifo_wdata,
          {bval(s+3), bval(s+2), bval(s+1), bval(s)});
    send_n(5);
    idle(2);
    exp_pkt(s, 9);
    verify("R1");

    // R3 / R2 / R6: count mode sweep, three packets back-to-back each
    for (int L = 1; L <= 11; L++) begin
      pkt_len_cfg = 6'(L);
      s = gseq;
      send_n(3 * L);
      idle(2);
      for (int p = 0; p < 3; p++) exp_pkt(s + p * L, L);
      verify("R3 R2 R6 count sweep");
    end

    // R3: zero setting gives one-byte packets
    pkt_len_cfg = 6'd0;
    s = gseq;
    send_n(3);
    idle(2);
    for (int p = 0; p < 3; p++) exp_pkt(s + p, 1);
    verify("R3 zero length");

    // R4: idle does not close in count mode
    pkt_len_cfg = 6'd6;
    s = gseq;
    send_n(2);
    idle(40);
    check("R4 no length during idle", 32'(ln), 32'(lcur));
    check("R4 no data during idle", 32'(dn), 32'(dcur));
    send_n(4);
    idle(2);
    exp_pkt(s, 6);
    verify("R4");

    // R5 / R2: idle mode sweep over lengths and limits
    mode_timeout = 1'b1;
    for (int t = 1; t <= 7; t += 3) begin
      idle_limit = 4'(t);
      for (int n = 1; n <= 9; n++) begin
        s = gseq;
        send_n(n);
        idle(t + 2);
        exp_pkt(s, n);
        verify("R5 R2 idle sweep");
      end
    end

    // R5: boundary of the idle limit
    idle_limit = 4'd4;
    s = gseq;
    send_byte(); idle(3); send_byte(); idle(3); send_byte();
    check("R5 gap of limit-1 keeps packet open", 32'(ln), 32'(lcur));
    idle(3);
    check("R5 no close one cycle early", 32'(lfifo_wr), 0);
    idle(1);
    check("R5 close at limit", 32'(lfifo_wr), 1);
    check("R5 length at limit", 32'(lfifo_wdata), 3);
    check("R6 last word with length", 32'(dfifo_wr), 1);
    idle(2);
    exp_pkt(s, 3);
    verify("R5 boundary");

    // R7: count ceiling splits a long packet
    idle_limit = 4'd3;
    s = gseq;
    send_n(70);
    idle(5);
    exp_pkt(s, 63);
    exp_pkt(s + 63, 7);
    verify("R7 ceiling");

    // R8: data queue full drops words, length kept
    mode_timeout = 1'b0; pkt_len_cfg = 6'd5;
    dfifo_full = 1'b1;
    s = gseq;
    send_n(5);
    idle(2);
    exp_len(5);
    verify("R8 data full");
    check("R8 overflow flag", 32'(ovf_flag), 1);
    dfifo_full = 1'b0;

    // R9: length queue full drops entry, data kept
    lfifo_full = 1'b1;
    s = gseq;
    send_n(5);
    idle(2);
    exp_data(s, 5);
    verify("R9 length full");
    check("R9 overflow flag", 32'(ovf_flag), 1);
    lfifo_full = 1'b0;

    // R10: flag stays set through normal traffic, clears on reset
    s = gseq;
    send_n(5);
    idle(4);
    exp_pkt(s, 5);
    verify("R10 normal after overflow");
    check("R10 flag sticky", 32'(ovf_flag), 1);
    do_reset();
    check("R10 flag cleared by reset", 32'(ovf_flag), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule